// File: doc/BRIEF.md
# Load-Delay Slot Filling Reorderer

This block holds a small buffer of 16-bit instructions and rewrites it in place so that, wherever it can, a load or a store is followed by an instruction that does not depend on it. The slot right after a memory access then does useful work instead of stalling. Software or a loader fills the buffer through a write port, sets the number of valid entries and pulses start. The block walks the buffer from entry 0 upward, and for each memory access it looks for the nearest instruction that may legally move into the slot. When it finds one, it moves that instruction up and shifts the instructions in between down by one. When the walk reaches the last valid entry it raises done, and the result is read back through a read port.

The search for a candidate runs as a series of sweeps. The first sweep uses the memory access as reference and sets a sticky mark on every later entry that conflicts with it. If the entry right after the reference is marked, the reference moves forward by one and another sweep runs, adding more marks. The first unmarked entry found this way is the candidate. Jump targets and branches act as barriers, so code is never reordered across control flow. A branch that is moved has its relative offset corrected. If the corrected offset does not fit, the move is cancelled. The block does one comparison or one copy per clock.

Top module: `slot_reorder`

## Requirements
- R1: After reset, `done` and `busy` are both 0.
- R2: Entries are visited in ascending order from entry 0. Only opcodes 0x1 (load) and 0x2 (store) in bits [15:12] start a search; other entries are skipped. A memory access in the last valid entry is left as it is.
- R3: Fields are opcode [15:12], A [11:8], B [7:4], C [3:0]. Load and opcodes 0x5..0xF write A. Load reads B, store reads A and B, branch (0x3) reads A, and opcodes 0x5..0xF read B and C. An entry conflicts with the reference if it reads a register the reference writes, if it writes a register the reference reads or writes, or if both are memory accesses.
- R4: Marks are sticky across the sweeps of one search. The candidate is the first entry after the current reference that is still unmarked. Moving a candidate from position y+1 to x+1 shifts entries x+1..y down by one position, and their order is kept.
- R5: A jump target (opcode 0x4) marks itself and every later entry in the same sweep.
- R6: A branch marks every later entry in the same sweep, but the branch itself is marked only by a conflict, so it can be moved.
- R7: When a branch moves up by k positions, k is added to its signed offset in bits [7:0]. Bits [15:8] are kept.
- R8: If the corrected offset falls outside -128..127, the move is cancelled and the buffer is left unchanged for that access.
- R9: If the entry right after the memory access is unmarked after the first sweep, no entry moves.
- R10: `done` rises when the walk ends, stays 1 until the next accepted start, and is never 1 while `busy` is 1. A start pulse and buffer writes that arrive while `busy` is 1 are ignored.
- R11: With a count of 0 or 1, the block finishes without changing the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one buffer entry (ignored while busy) |
| wrAddr | input | 4 | Entry written |
| wrData | input | 16 | Instruction written |
| instCount | input | 5 | Number of valid entries, sampled at start |
| start | input | 1 | Start pulse (ignored while busy) |
| rdAddr | input | 4 | Entry read |
| rdData | output | 16 | Instruction at rdAddr (combinational) |
| busy | output | 1 | Reordering in progress |
| done | output | 1 | Last run completed |

## Verification
The bench builds programs in which the right candidate lies several sweeps away. A design that clears marks between sweeps, or that stops after the first sweep, picks the wrong instruction or none. Barrier cases put an independent instruction behind a jump target or behind a branch that conflicts with the access. A design that ignores a barrier moves that instruction across control flow. Branch cases check the offset correction both in range and at +127, where a missing overflow test would wrap the offset to -128. Further cases cover the memory-against-memory and write-after-read conflicts, a candidate two positions down (which shows whether the shift keeps the order), accesses at the last entry, short counts, and writes or start pulses issued during a run. A block that accepts those corrupts the buffer mid-run.

// File: rtl/slot_reorder_pkg.sv
package slot_reorder_pkg;

  localparam int INSN_W = 16;

  localparam logic [3:0] OP_NOP    = 4'h0;
  localparam logic [3:0] OP_LOAD   = 4'h1;
  localparam logic [3:0] OP_STORE  = 4'h2;
  localparam logic [3:0] OP_BRANCH = 4'h3;
  localparam logic [3:0] OP_TARGET = 4'h4;
  localparam logic [3:0] OP_ALU_LO = 4'h5;

  // strobes from control to datapath
  typedef struct packed {
    logic countLoad;
    logic headClr;
    logic headInc;
    logic refFromHead;
    logic refInc;
    logic traceFromHead;
    logic traceFromRef;
    logic traceInc;
    logic depClr;
    logic sweepEn;
    logic tempLoad;
    logic ptrFromRef;
    logic ptrDec;
    logic shiftEn;
    logic fillEn;
  } ctrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic headLatent;
    logic headAtEnd;
    logic traceAtEnd;
    logic candMarked;
    logic candIsLast;
    logic refIsHead;
    logic candBranch;
    logic offOverflow;
    logic ptrAtBottom;
  } stat_t;

  function automatic logic isMem(input logic [INSN_W-1:0] i);
    return (i[15:12] == OP_LOAD) || (i[15:12] == OP_STORE);
  endfunction

  function automatic logic writesA(input logic [INSN_W-1:0] i);
    return (i[15:12] == OP_LOAD) || (i[15:12] >= OP_ALU_LO);
  endfunction

  function automatic logic readsA(input logic [INSN_W-1:0] i);
    return (i[15:12] == OP_STORE) || (i[15:12] == OP_BRANCH);
  endfunction

  function automatic logic readsB(input logic [INSN_W-1:0] i);
    return isMem(i) || (i[15:12] >= OP_ALU_LO);
  endfunction

  function automatic logic readsC(input logic [INSN_W-1:0] i);
    return i[15:12] >= OP_ALU_LO;
  endfunction

  // does cand read a register that writer produces
  function automatic logic readsRegOf(input logic [INSN_W-1:0] rdr,
                                      input logic [3:0] regIdx);
    return (readsA(rdr) && rdr[11:8] == regIdx) ||
           (readsB(rdr) && rdr[7:4]  == regIdx) ||
           (readsC(rdr) && rdr[3:0]  == regIdx);
  endfunction

  function automatic logic conflicts(input logic [INSN_W-1:0] cand,
                                     input logic [INSN_W-1:0] refI);
    logic raw, war, waw, mem;
    raw = writesA(refI) && readsRegOf(cand, refI[11:8]);
    war = writesA(cand) && readsRegOf(refI, cand[11:8]);
    waw = writesA(refI) && writesA(cand) && (refI[11:8] == cand[11:8]);
    mem = isMem(refI) && isMem(cand);
    return raw || war || waw || mem;
  endfunction

endpackage

// File: rtl/slot_reorder_dp.sv
module slot_reorder_dp
  import slot_reorder_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic              busy,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [INSN_W-1:0] wrData,
  input  logic [CW-1:0]     instCount,
  input  logic [AW-1:0]     rdAddr,
  output logic [INSN_W-1:0] rdData,
  output stat_t             stat
);

  logic [INSN_W-1:0] memQ [DEPTH];
  logic [DEPTH-1:0]  depQ;
  logic [AW-1:0]     headQ, refQ, traceQ, ptrQ;
  logic [CW-1:0]     countQ;
  logic              barrierQ;
  logic [INSN_W-1:0] tempQ;

  logic [AW-1:0]     candIdx;
  logic [INSN_W-1:0] candIns, traceIns, refIns, headIns;
  logic [AW-1:0]     kDist;
  logic [8:0]        offSum;
  logic              barNow, markNow;

  assign candIdx  = refQ + AW'(1);
  assign candIns  = memQ[candIdx];
  assign traceIns = memQ[traceQ];
  assign refIns   = memQ[refQ];
  assign headIns  = memQ[headQ];
  assign kDist    = refQ - headQ;
  assign offSum   = {candIns[7], candIns[7:0]} + 9'(kDist);

  assign barNow  = barrierQ || (traceIns[15:12] == OP_TARGET);
  assign markNow = barNow || conflicts(traceIns, refIns);

  assign rdData = memQ[rdAddr];

  always_comb begin
    stat.headLatent  = isMem(headIns);
    stat.headAtEnd   = (CW'(headQ) + CW'(1)) >= countQ;
    stat.traceAtEnd  = (CW'(traceQ) + CW'(1)) >= countQ;
    stat.candMarked  = depQ[candIdx];
    stat.candIsLast  = (CW'(refQ) + CW'(2)) >= countQ;
    stat.refIsHead   = refQ == headQ;
    stat.candBranch  = candIns[15:12] == OP_BRANCH;
    stat.offOverflow = offSum[8] ^ offSum[7];
    stat.ptrAtBottom = ptrQ == (headQ + AW'(1));
  end

  // pointer registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ    <= '0;
      refQ     <= '0;
      traceQ   <= '0;
      ptrQ     <= '0;
      countQ   <= '0;
      barrierQ <= 1'b0;
    end else begin
      if (ctrl.countLoad) countQ <= instCount;
      if (ctrl.headClr)      headQ <= '0;
      else if (ctrl.headInc) headQ <= headQ + AW'(1);
      if (ctrl.refFromHead)  refQ <= headQ;
      else if (ctrl.refInc)  refQ <= refQ + AW'(1);
      if (ctrl.traceFromHead)     traceQ <= headQ + AW'(1);
      else if (ctrl.traceFromRef) traceQ <= refQ + AW'(2);
      else if (ctrl.traceInc)     traceQ <= traceQ + AW'(1);
      if (ctrl.ptrFromRef)   ptrQ <= refQ;
      else if (ctrl.ptrDec)  ptrQ <= ptrQ - AW'(1);
      if (ctrl.traceFromHead || ctrl.traceFromRef) barrierQ <= 1'b0;
      else if (ctrl.sweepEn)
        barrierQ <= barNow || (traceIns[15:12] == OP_BRANCH);
    end
  end

  // sticky dependency marks
  always_ff @(posedge clk) begin
    if (!rstN) depQ <= '0;
    else if (ctrl.depClr) depQ <= '0;
    else if (ctrl.sweepEn && markNow) depQ[traceQ] <= 1'b1;
  end

  // saved candidate, with branch offset corrected
  always_ff @(posedge clk) begin
    if (!rstN) tempQ <= '0;
    else if (ctrl.tempLoad)
      tempQ <= stat.candBranch ? {candIns[15:8], offSum[7:0]} : candIns;
  end

  // instruction buffer
  always_ff @(posedge clk) begin
    if (ctrl.shiftEn)      memQ[ptrQ + AW'(1)]  <= memQ[ptrQ];
    else if (ctrl.fillEn)  memQ[headQ + AW'(1)] <= tempQ;
    else if (wrEn && !busy) memQ[wrAddr] <= wrData;
  end

  AST_STICKY_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sweepEn |=> ((depQ & $past(depQ)) == $past(depQ)));  // R4
  AST_TRACE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sweepEn |-> (traceQ > refQ) && (CW'(traceQ) < countQ));  // R4
  AST_MOVE_UNMARKED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.tempLoad |-> !depQ[candIdx]);  // R4
  AST_SHIFT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |-> (ptrQ > headQ) && (ptrQ <= refQ));  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.tempLoad && stat.candBranch) |-> !stat.offOverflow);  // R8

endmodule

// File: rtl/slot_reorder_ctrl.sv
module slot_reorder_ctrl
  import slot_reorder_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_SWEEP, ST_CHECK, ST_SHIFT, ST_FILL
  } state_t;

  state_t stateQ, stateD;
  logic   doneQ, doneSet, doneClr;

  always_comb begin
    ctrl    = '0;
    stateD  = stateQ;
    doneSet = 1'b0;
    doneClr = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.countLoad = 1'b1;
          ctrl.headClr   = 1'b1;
          doneClr        = 1'b1;
          stateD         = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (stat.headAtEnd) begin
          doneSet = 1'b1;
          stateD  = ST_IDLE;
        end else if (stat.headLatent) begin
          ctrl.refFromHead   = 1'b1;
          ctrl.traceFromHead = 1'b1;
          ctrl.depClr        = 1'b1;
          stateD             = ST_SWEEP;
        end else begin
          ctrl.headInc = 1'b1;
        end
      end
      ST_SWEEP: begin
        ctrl.sweepEn = 1'b1;
        if (stat.traceAtEnd) stateD = ST_CHECK;
        else                 ctrl.traceInc = 1'b1;
      end
      ST_CHECK: begin
        if (!stat.candMarked) begin
          if (stat.refIsHead || (stat.candBranch && stat.offOverflow)) begin
            ctrl.headInc = 1'b1;
            stateD       = ST_SCAN;
          end else begin
            ctrl.tempLoad   = 1'b1;
            ctrl.ptrFromRef = 1'b1;
            stateD          = ST_SHIFT;
          end
        end else if (stat.candIsLast) begin
          ctrl.headInc = 1'b1;
          stateD       = ST_SCAN;
        end else begin
          ctrl.refInc       = 1'b1;
          ctrl.traceFromRef = 1'b1;
          stateD            = ST_SWEEP;
        end
      end
      ST_SHIFT: begin
        ctrl.shiftEn = 1'b1;
        if (stat.ptrAtBottom) stateD = ST_FILL;
        else                  ctrl.ptrDec = 1'b1;
      end
      ST_FILL: begin
        ctrl.fillEn  = 1'b1;
        ctrl.headInc = 1'b1;
        stateD       = ST_SCAN;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (doneSet)      doneQ <= 1'b1;
      else if (doneClr) doneQ <= 1'b0;
    end
  end

  assign busy = stateQ != ST_IDLE;
  assign done = doneQ;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);  // R10
  AST_MOVE_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fillEn |-> $past(ctrl.shiftEn));  // R4

endmodule

// File: rtl/slot_reorder.sv
module slot_reorder
  import slot_reorder_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [INSN_W-1:0] wrData,
  input  logic [CW-1:0]     instCount,
  input  logic              start,
  input  logic [AW-1:0]     rdAddr,
  output logic [INSN_W-1:0] rdData,
  output logic              busy,
  output logic              done
);

  ctrl_t ctrl;
  stat_t stat;

  slot_reorder_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  slot_reorder_dp #(.DEPTH(DEPTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .busy      (busy),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .instCount (instCount),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .stat      (stat)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rstN) |-> !busy && !done);  // R1

endmodule

// File: tb/slot_reorder_tb.sv
module slot_reorder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [4:0]  instCount = '0;
  logic        start = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;

  typedef logic [15:0] prog_t [16];

  always #5 clk = ~clk;

  slot_reorder dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .instCount(instCount), .start(start), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] mk(input int op, input int a, input int b, input int c);
    return {4'(op), 4'(a), 4'(b), 4'(c)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadProg(input prog_t p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 4'(i); wrData = p[i];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runWait(input int n);
    @(negedge clk);
    instCount = 5'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 4000 && !done; t++) @(negedge clk);
  endtask

  task automatic checkBuf(input string req, input prog_t e, input int n);
    chk(req, {31'b0, done}, 32'd1);
    for (int i = 0; i < n; i++) begin
      rdAddr = 4'(i);
      #1;
      chk(req, {16'b0, rdData}, {16'b0, e[i]});
    end
  endtask

  task automatic runCase(input string req, input prog_t p, input prog_t e, input int n);
    loadProg(p, n);
    runWait(n);
    checkBuf(req, e, n);
  endtask

  // R3 RAW then R4 two sweeps, one-step shift
  task automatic tRawTwoSweeps();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = 16'h5567;
    e[0] = 16'h1120; e[1] = 16'h5567; e[2] = 16'h5314;
    runCase("R3 R4 raw", p, e, 3);
  endtask

  // R9 independent entry already in the slot
  task automatic tAlreadyFilled();
    prog_t p = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5567; p[2] = 16'h5314;
    runCase("R9 no move", p, p, 3);
  endtask

  // R3 memory against memory conflict
  task automatic tMemMem();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h2340; p[2] = 16'h5567;
    e[0] = 16'h1120; e[1] = 16'h5567; e[2] = 16'h2340;
    runCase("R3 mem-mem", p, e, 3);
  endtask

  // R3 write-after-read conflict
  task automatic tWar();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5256; p[2] = 16'h5789;
    e[0] = 16'h1120; e[1] = 16'h5789; e[2] = 16'h5256;
    runCase("R3 war", p, e, 3);
  endtask

  // R2 skip non-memory entry, R4 shift by two, second access later
  task automatic tTwoAccesses();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = 16'h5534; p[3] = 16'h5678;
    p[4] = 16'h29A0; p[5] = 16'h5A11; p[6] = 16'h5B3C;
    e[0] = 16'h1120; e[1] = 16'h5678; e[2] = 16'h5314; e[3] = 16'h5534;
    e[4] = 16'h29A0; e[5] = 16'h5B3C; e[6] = 16'h5A11;
    runCase("R4 R2 shift2", p, e, 7);
  endtask

  // R2 first entry skipped, access at index 1
  task automatic tSkipFirst();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h5567; p[1] = 16'h1120; p[2] = 16'h5314; p[3] = 16'h589A;
    e[0] = 16'h5567; e[1] = 16'h1120; e[2] = 16'h589A; e[3] = 16'h5314;
    runCase("R2 skip", p, e, 4);
  endtask

  // R2 access in the last entry is left alone
  task automatic tLastAccess();
    prog_t p = '{default: 16'h0};
    p[0] = 16'h5567; p[1] = 16'h5314; p[2] = 16'h1120;
    runCase("R2 last", p, p, 3);
  endtask

  // R5 jump target blocks the candidate behind it
  task automatic tTargetBarrier();
    prog_t p = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = mk(4, 0, 0, 0); p[3] = 16'h5567;
    runCase("R5 target", p, p, 4);
  endtask

  // R6 a conflicting branch blocks later entries
  task automatic tBranchBarrier();
    prog_t p = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = 16'h3103; p[3] = 16'h5567;
    runCase("R6 branch barrier", p, p, 4);
  endtask

  // R6 R7 branch moves up by one, offset +1
  task automatic tBranchMove();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = 16'h3705;
    e[0] = 16'h1120; e[1] = 16'h3706; e[2] = 16'h5314;
    runCase("R7 offset", p, e, 3);
    p[2] = 16'h3780; e[1] = 16'h3781;
    runCase("R7 negative offset", p, e, 3);
  endtask

  // R8 overflow at +127 cancels the move
  task automatic tOverflow();
    prog_t p = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = 16'h377F;
    runCase("R8 overflow", p, p, 3);
  endtask

  // R11 short counts
  task automatic tShort();
    prog_t p = '{default: 16'h0};
    p[0] = 16'h1120;
    runCase("R11 count1", p, p, 1);
    runWait(0);
    chk("R11 count0 done", {31'b0, done}, 32'd1);
  endtask

  // R10 start and writes ignored while busy, done cleared on start
  task automatic tBusyIgnore();
    prog_t p = '{default: 16'h0};
    prog_t e = '{default: 16'h0};
    p[0] = 16'h1120; p[1] = 16'h5314; p[2] = 16'h5534; p[3] = 16'h5678;
    e[0] = 16'h1120; e[1] = 16'h5678; e[2] = 16'h5314; e[3] = 16'h5534;
    loadProg(p, 4);
    @(negedge clk);
    instCount = 5'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", {30'b0, busy, done}, 32'h2);
    wrEn = 1'b1; wrAddr = 4'd0; wrData = 16'hFFFF; start = 1'b1; instCount = 5'd2;
    @(negedge clk);
    wrEn = 1'b0; start = 1'b0;
    wrAddr = 4'd3; wrData = 16'hEEEE;
    @(negedge clk);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    for (int t = 0; t < 4000 && !done; t++) @(negedge clk);
    checkBuf("R10 ignore while busy", e, 4);
    repeat (3) @(negedge clk);
    chk("R10 done held", {30'b0, busy, done}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", {30'b0, busy, done}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {30'b0, busy, done}, 32'h0);
    tRawTwoSweeps();
    tAlreadyFilled();
    tMemMem();
    tWar();
    tTwoAccesses();
    tSkipFirst();
    tLastAccess();
    tTargetBarrier();
    tBranchBarrier();
    tBranchMove();
    tOverflow();
    tShort();
    tBusyIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule